// File: doc/BRIEF.md
# Two-Entry Receive Holding Buffer

This block sits between a serial deframer and a host read port. Each time the deframer finishes a frame, it raises a one-cycle strobe. The strobe carries an 8-bit word, a ninth data bit and a framing-error flag. The block queues up to two such words. Each word keeps its ninth bit and framing flag next to it, so the status shown at the output always belongs to the word at the head of the queue. A host read removes the head entry and brings the next entry's data and status forward. For this reason the host must sample the status before it reads the data.

A read-only "data available" flag is high while at least one word is queued. That flag, gated by a separate enable, drives the interrupt output. If a frame completes while both slots are occupied and no read frees one, the word is lost and a sticky overrun flag rises. While that flag is set, every later frame is dropped, even after the host has freed space. The only way out is to drop the receive enable for a cycle. This also empties the queue.

Top module: `rx_hold_buf`

## Requirements
- R1: The buffer holds at most two words and returns them in arrival order; `rx_avail_o` is high exactly when at least one word is held.
- R2: A `frm_valid_i` strobe with `rx_en_i` high, `overrun_o` low and a free slot (or a read in the same cycle) stores the word, visible on the outputs after the next clock edge.
- R3: A `frm_valid_i` strobe with `rx_en_i` high, both slots full and no read in the same cycle sets `overrun_o` after the next clock edge and the word is discarded.
- R4: While `overrun_o` is high, no strobe stores a word, even when a slot is free.
- R5: With `rx_en_i` low, the next edge empties the buffer and clears `overrun_o`; strobes and reads are ignored while it is low.
- R6: `head_bit9_o` and `head_ferr_o` always belong to the entry shown on `rd_data_o`, and a read advances all three together.
- R7: `rx_avail_o` is set only by a stored word and is cleared by hardware once the last held word has been read.
- R8: `irq_o` is high exactly when `rx_avail_o` and `irq_en_i` are both high.
- R9: A store and a read in the same cycle are both performed and the occupancy stays the same, including when both slots are full.
- R10: A read of an empty buffer changes nothing. The outputs keep the data, ninth bit and framing flag of the last word read.
- R11: After reset, the buffer is empty, `overrun_o` is low and the data and status outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable; low flushes the buffer and clears overrun |
| frm_valid_i | input | 1 | Frame-done strobe from the deframer |
| frm_data_i | input | 8 | Received word |
| frm_bit9_i | input | 1 | Received ninth bit |
| frm_ferr_i | input | 1 | Framing error of the received word |
| rd_i | input | 1 | Host read: pops the head entry |
| irq_en_i | input | 1 | Interrupt enable |
| rd_data_o | output | 8 | Head word (last read word when empty) |
| head_bit9_o | output | 1 | Ninth bit of the head entry |
| head_ferr_o | output | 1 | Framing error of the head entry |
| rx_avail_o | output | 1 | Data-available flag |
| irq_o | output | 1 | Gated receive interrupt |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench targets four corner cases. The first is the third frame arriving while both slots are full. A design that got it wrong would either overwrite a queued word or miss the overrun. The second is a frame arriving after a read has freed a slot while overrun is still set. A faulty design would accept that word. The third is a store and a read in the same cycle with the queue full; an error here would show up as an overrun or a lost count. The fourth is a read of an empty queue, where a wrong design would wrap the pointers and expose stale entries. The bench also checks status ordering after every read, so ninth bits or framing flags that drift onto the wrong word show up as mismatches.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              bit9;
    logic              ferr;
  } rxb_entry_t;
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo
  import rxb_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  rxb_entry_t                   entry_i,
  input  logic                         pop_i,
  output rxb_entry_t                   head_o,
  output logic                         empty_o,
  output logic                         full_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);

  rxb_entry_t       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (push_i && !flush_i) begin
      mem_q[wr_ptr_q] <= entry_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      unique case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == FULL_CNT);
  assign count_o = count_q;

  assert_no_overflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_CNT);
  assert_flush_empties_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0));
  assert_push_pop_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !flush_i) |=> $stable(count_q));
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
  import rxb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_en_i,
  input  logic       frm_valid_i,
  input  logic       rd_i,
  input  logic       empty_i,
  input  logic       full_i,
  input  rxb_entry_t head_i,
  output logic       push_o,
  output logic       pop_o,
  output logic       flush_o,
  output logic       overrun_o,
  output rxb_entry_t view_o
);
  logic       ovr_q;
  logic       room, ovr_set;
  rxb_entry_t last_q;

  assign flush_o = !rx_en_i;
  assign pop_o   = rx_en_i && rd_i && !empty_i;
  // a same-cycle read frees the slot the incoming word needs
  assign room    = !full_i || pop_o;
  assign push_o  = rx_en_i && frm_valid_i && !ovr_q && room;
  assign ovr_set = rx_en_i && frm_valid_i && !ovr_q && !room;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q  <= 1'b0;
      last_q <= '0;
    end else begin
      if (!rx_en_i)     ovr_q <= 1'b0;
      else if (ovr_set) ovr_q <= 1'b1;
      if (pop_o) last_q <= head_i;
    end
  end

  assign overrun_o = ovr_q;
  assign view_o    = empty_i ? last_q : head_i;

  assert_overrun_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && frm_valid_i && full_i && !rd_i) |=> ovr_q);
  assert_overrun_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && rx_en_i) |=> ovr_q);
  assert_overrun_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !ovr_q);
endmodule

// File: rtl/rx_hold_buf.sv
module rx_hold_buf
  import rxb_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              frm_valid_i,
  input  logic [DATA_W-1:0] frm_data_i,
  input  logic              frm_bit9_i,
  input  logic              frm_ferr_i,
  input  logic              rd_i,
  input  logic              irq_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              head_bit9_o,
  output logic              head_ferr_o,
  output logic              rx_avail_o,
  output logic              irq_o,
  output logic              overrun_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  rxb_entry_t       in_entry, head, view;
  logic             push, pop, flush, empty, full;
  logic [CNT_W-1:0] count;

  assign in_entry = '{data: frm_data_i, bit9: frm_bit9_i, ferr: frm_ferr_i};

  rxb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (push),
    .entry_i (in_entry),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (empty),
    .full_o  (full),
    .count_o (count)
  );

  rxb_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_en_i     (rx_en_i),
    .frm_valid_i (frm_valid_i),
    .rd_i        (rd_i),
    .empty_i     (empty),
    .full_i      (full),
    .head_i      (head),
    .push_o      (push),
    .pop_o       (pop),
    .flush_o     (flush),
    .overrun_o   (overrun_o),
    .view_o      (view)
  );

  assign rd_data_o   = view.data;
  assign head_bit9_o = view.bit9;
  assign head_ferr_o = view.ferr;
  assign rx_avail_o  = !empty;
  assign irq_o       = rx_avail_o && irq_en_i;

  assert_no_store_in_overrun_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && rx_en_i) |=> (count <= $past(count)));
  assert_empty_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && rd_i && !rx_avail_o && !frm_valid_i) |=> (!rx_avail_o && $stable(rd_data_o)));
  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
  assert_avail_from_store_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_avail_o) |-> $past(frm_valid_i && rx_en_i));
endmodule

// File: tb/rx_hold_buf_tb.sv
module rx_hold_buf_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       en = 1'b0, fv = 1'b0, b9 = 1'b0, fe = 1'b0, rd = 1'b0, ie = 1'b0;
  logic [7:0] d = '0;
  logic [7:0] rd_data;
  logic       h9, hf, avail, irq, ovr;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model: q[0] is head
  logic [9:0] q [2];
  int         m_cnt = 0;
  bit         m_ovr = 0;
  logic [9:0] m_last = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_hold_buf u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(en), .frm_valid_i(fv),
    .frm_data_i(d), .frm_bit9_i(b9), .frm_ferr_i(fe), .rd_i(rd),
    .irq_en_i(ie), .rd_data_o(rd_data), .head_bit9_o(h9), .head_ferr_o(hf),
    .rx_avail_o(avail), .irq_o(irq), .overrun_o(ovr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_view();
    return (m_cnt > 0) ? q[0] : m_last;
  endfunction

  task automatic check_all();
    logic [9:0] v;
    v = exp_view();
    chk("R1", "avail", int'(avail), int'(m_cnt > 0));
    chk("R2", "data", int'(rd_data), int'(v[9:2]));
    chk("R6", "bit9", int'(h9), int'(v[1]));
    chk("R6", "ferr", int'(hf), int'(v[0]));
    chk("R3", "overrun", int'(ovr), int'(m_ovr));
    chk("R8", "irq", int'(irq), int'((m_cnt > 0) && ie));
  endtask

  function automatic void model_step(bit i_en, bit i_fv, logic [9:0] i_e, bit i_rd);
    bit pop, room;
    if (!i_en) begin
      m_cnt = 0; m_ovr = 0;
      return;
    end
    pop  = i_rd && (m_cnt > 0);
    room = (m_cnt < 2) || pop;
    if (pop) begin
      m_last = q[0]; q[0] = q[1]; m_cnt--;
    end
    if (i_fv && !m_ovr) begin
      if (room) begin q[m_cnt] = i_e; m_cnt++; end
      else m_ovr = 1;
    end
  endfunction

  // drive at negedge, model the coming edge, check at the following negedge
  task automatic step(bit i_en, bit i_fv, logic [7:0] i_d, bit i_b9, bit i_fe, bit i_rd, bit i_ie);
    en = i_en; fv = i_fv; d = i_d; b9 = i_b9; fe = i_fe; rd = i_rd; ie = i_ie;
    model_step(i_en, i_fv, {i_d, i_b9, i_fe}, i_rd);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    // R11: reset state
    chk("R11", "avail", int'(avail), 0);
    chk("R11", "overrun", int'(ovr), 0);
    chk("R11", "data", int'(rd_data), 0);
    chk("R11", "status", int'({h9, hf}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1, 0, 8'h00, 0, 0, 0, 1);
    // R10: read empty
    step(1, 0, 8'h00, 0, 0, 1, 1);
    // R2/R6: fill two with distinct status
    step(1, 1, 8'hA5, 1, 0, 0, 1);
    step(1, 1, 8'h3C, 0, 1, 0, 1);
    // R3: third frame while full
    step(1, 1, 8'hFF, 1, 1, 0, 1);
    // R4: free a slot, frame still dropped
    step(1, 0, 8'h00, 0, 0, 1, 1);
    step(1, 1, 8'h77, 1, 1, 0, 0);
    step(1, 0, 8'h00, 0, 0, 1, 1);
    chk("R7", "avail cleared", int'(avail), 0);
    // R10: empty read keeps last word
    step(1, 0, 8'h00, 0, 0, 1, 1);
    chk("R10", "last data", int'(rd_data), 8'h3C);
    // R5: disable clears overrun, ignores strobes
    step(0, 1, 8'h11, 0, 0, 0, 1);
    chk("R5", "overrun cleared", int'(ovr), 0);
    step(1, 1, 8'h21, 0, 0, 0, 1);
    step(1, 1, 8'h22, 1, 0, 0, 1);
    // R9: store and read together while full
    step(1, 1, 8'h23, 0, 1, 1, 1);
    chk("R9", "no overrun", int'(ovr), 0);
    chk("R9", "head", int'(rd_data), 8'h22);
    step(0, 0, 8'h00, 0, 0, 1, 1);
    chk("R5", "flushed", int'(avail), 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit r_en, r_fv, r_rd, r_ie;
      r_en = ($urandom_range(0, 31) != 0);
      r_fv = ($urandom_range(0, 2) == 0);
      r_rd = ($urandom_range(0, 3) == 0);
      r_ie = ($urandom_range(0, 3) != 0);
      step(r_en, r_fv, 8'($urandom), 1'($urandom), 1'($urandom), r_rd, r_ie);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule